// File: doc/BRIEF.md
# Programmable even clock divider

This block produces the CPU clock timing from a free-running oscillator clock. Software writes an 8-bit divide value N through a simple write port (data plus strobe). For N of 1 or more, the block divides the oscillator by 2N and keeps a 50% duty cycle. For N equal to 0, it runs in pass-through, where every oscillator cycle is a CPU cycle. Downstream logic receives the timing in two forms. The first is a one-cycle clock-enable pulse, `cclk_en`, which marks the first oscillator cycle of every output period. The second is a phase level, `cclk_lvl`, which is high for the first half of each period and low for the second half.

The divide value can be rewritten at any moment, and the output keeps running through the change. A written value is stored at once and read back at once. It becomes active only when the period in progress completes, so a period that has started is never cut short or stretched. A separate low-power flag bit has its own write strobe. It is a plain software-visible flag with no effect on the division, and it clears on reset like the divide value.

Top module: `evd_top`

## Requirements
- R1: For an active N of 1 or more, `cclk_en` is high for exactly one oscillator cycle in every 2N cycles, so the largest ratio (N = 255) gives one pulse every 510 cycles.
- R2: For an active N of 1 or more, `cclk_lvl` is high for N cycles and then low for N cycles. `cclk_en` is high in the first high cycle of each period.
- R3: While the active N is 0 (pass-through), `cclk_en` and `cclk_lvl` are both high in every cycle.
- R4: A value written on a clock edge becomes active at the first period boundary after that edge. A write that lands on the final cycle of a period therefore waits one further full period. The period in progress keeps its old length.
- R5: A change between pass-through and a divided mode, or between two divide values, happens only after a complete low half. `cclk_lvl` rises only at the start of a period.
- R6: `div_rdata` returns the last value written through `div_wr`/`div_wdata` from the cycle after the write, whether or not that value is active yet.
- R7: `lp_q` takes `lp_wdata` on the edge where `lp_wr` is high. It has no effect on `cclk_en` or `cclk_lvl`.
- R8: While `rst_n` is low, and after it is released, the divide value and `lp_q` are 0, and the block is in pass-through with `cclk_en` and `cclk_lvl` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the divide value |
| div_wdata | input | 8 | Divide value N to store |
| lp_wr | input | 1 | Write strobe for the low-power flag |
| lp_wdata | input | 1 | Low-power flag value to store |
| cclk_en | output | 1 | One-cycle pulse at the start of each output period |
| cclk_lvl | output | 1 | Output phase: high for the first half of each period |
| div_rdata | output | 8 | Readback of the stored divide value |
| lp_q | output | 1 | Readback of the low-power flag |

## Verification
The store of a new divide value and the end of an output period can fall in the same oscillator cycle. When they do, the new value must not become active at that boundary; it waits for the next one. The bench provokes this by writing a changing value on every cycle for a long stretch, so writes land on every position of the period, including the final cycle. The behavioural model tracks the pending value and the position within the period separately, and the bench compares pulse, phase and readback against it on every clock.

// File: rtl/evd_pkg.sv
package evd_pkg;

  // Output phase of the divided clock.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } evd_phase_e;

  // Number of oscillator cycles in one output period for divide value n.
  function automatic int unsigned evd_period_len(input int unsigned n);
    return (n == 0) ? 1 : 2 * n;
  endfunction

  // Index of the final cycle of a half period for divide value n (n >= 1).
  function automatic int unsigned evd_half_last(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/evd_regs.sv
module evd_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_wr,
  input  logic [DW-1:0] div_wdata,
  input  logic          lp_wr,
  input  logic          lp_wdata,
  output logic [DW-1:0] n_q,
  output logic          lp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q  <= '0;
      lp_q <= 1'b0;
    end else begin
      if (div_wr) n_q  <= div_wdata;
      if (lp_wr)  lp_q <= lp_wdata;
    end
  end

  AST_DIV_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (n_q == $past(div_wdata)));                        // R6
  AST_LP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    lp_wr |=> (lp_q == $past(lp_wdata)));                         // R7
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_wr && $past(rst_n)) |=> $stable(n_q));                  // R6

endmodule

// File: rtl/evd_seq.sv
module evd_seq
  import evd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] n_req,
  output logic          cke,
  output logic          lvl,
  output logic [DW-1:0] n_act_o,
  output logic          period_end_o
);

  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] n_act;
  logic [DW-1:0] cnt;
  evd_phase_e    ph;

  // Named events, also used by the assertions below.
  logic pass_mode;
  logic half_end;
  logic period_end;

  assign pass_mode  = (n_act == '0);
  assign half_end   = !pass_mode && (cnt == (n_act - ONE));
  assign period_end = pass_mode || (half_end && (ph == PH_LOW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_act <= '0;
      cnt   <= '0;
      ph    <= PH_HIGH;
    end else if (period_end) begin
      n_act <= n_req;
      cnt   <= '0;
      ph    <= PH_HIGH;
    end else if (half_end) begin
      cnt   <= '0;
      ph    <= PH_LOW;
    end else begin
      cnt   <= cnt + ONE;
    end
  end

  assign cke          = pass_mode || ((ph == PH_HIGH) && (cnt == '0));
  assign lvl          = (ph == PH_HIGH);
  assign n_act_o      = n_act;
  assign period_end_o = period_end;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_mode |-> (cnt < n_act));                                // R2
  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pass_mode |-> (cke && lvl));                                  // R3
  AST_ACT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(n_act)) |-> $past(period_end));     // R4
  AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(lvl)) |-> $past(half_end));            // R2
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(lvl)) |-> ($past(period_end) && cke)); // R5

endmodule

// File: rtl/evd_top.sv
module evd_top #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             lp_wr,
  input  logic             lp_wdata,
  output logic             cclk_en,
  output logic             cclk_lvl,
  output logic [DIV_W-1:0] div_rdata,
  output logic             lp_q
);

  logic [DIV_W-1:0] n_stored;
  logic [DIV_W-1:0] n_active;
  logic             boundary;

  evd_regs #(.DW(DIV_W)) u_regs (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .div_wr   (div_wr),
    .div_wdata(div_wdata),
    .lp_wr    (lp_wr),
    .lp_wdata (lp_wdata),
    .n_q      (n_stored),
    .lp_q     (lp_q)
  );

  evd_seq #(.DW(DIV_W)) u_seq (
    .clk         (clk_osc),
    .rst_n       (rst_n),
    .n_req       (n_stored),
    .cke         (cclk_en),
    .lvl         (cclk_lvl),
    .n_act_o     (n_active),
    .period_end_o(boundary)
  );

  assign div_rdata = n_stored;

  AST_RESET_PASS: assert property (@(posedge clk_osc)
    !rst_n |=> (cclk_en && cclk_lvl && (div_rdata == '0) && !lp_q)); // R8
  AST_PULSE_IS_BOUNDARY_NEXT: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ($past(rst_n) && $past(boundary)) |-> cclk_en);                 // R1

endmodule

// File: tb/evd_top_test.sv
`timescale 1ns/1ps
module evd_top_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_wr;
  logic [7:0] div_wdata;
  logic       lp_wr;
  logic       lp_wdata;
  logic       cclk_en;
  logic       cclk_lvl;
  logic [7:0] div_rdata;
  logic       lp_q;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // Behavioural model state
  int m_pend;   // last written value
  int m_n;      // value governing the current period
  int m_pos;    // position inside current period
  int m_lp;

  always #2 clk = ~clk;  // 250 MHz

  evd_top uut (
    .clk_osc(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .lp_wr(lp_wr), .lp_wdata(lp_wdata), .cclk_en(cclk_en), .cclk_lvl(cclk_lvl),
    .div_rdata(div_rdata), .lp_q(lp_q)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare(input string tag);
    int e_cke, e_lvl;
    e_cke = (m_n == 0 || m_pos == 0) ? 1 : 0;
    e_lvl = (m_n == 0 || m_pos < m_n) ? 1 : 0;
    chk({tag, " R1/R2 cclk_en"}, int'(cclk_en), e_cke);
    chk({tag, " R2/R5 cclk_lvl"}, int'(cclk_lvl), e_lvl);
    chk({tag, " R6 div_rdata"}, int'(div_rdata), m_pend);
    chk({tag, " R7 lp_q"}, int'(lp_q), m_lp);
  endtask

  task automatic model_reset();
    m_pend = 0; m_n = 0; m_pos = 0; m_lp = 0;
  endtask

  // One oscillator cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic cyc(input bit dw, input int dv, input bit lw, input bit lv, input string tag);
    div_wr = dw; div_wdata = 8'(dv); lp_wr = lw; lp_wdata = lv;
    @(posedge clk);
    if ((m_n == 0) || (m_pos == 2 * m_n - 1)) begin
      m_n = m_pend; m_pos = 0;
    end else begin
      m_pos++;
    end
    if (dw) m_pend = dv;
    if (lw) m_lp = lv;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; div_wr = 0; div_wdata = 0; lp_wr = 0; lp_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    compare("R8 in-reset");
    rst_n = 1'b1;
  endtask

  initial begin
    int gap, last;
    do_reset();
    idle(4, "R8 R3 after reset");

    // R1: divide by 2
    cyc(1, 1, 0, 0, "R1 write1");
    idle(12, "R1 n1");
    // R2: divide by 6
    cyc(1, 3, 0, 0, "R2 write3");
    idle(24, "R2 n3");
    // R4: write mid-period, old period completes
    idle(2, "R4 pre");
    cyc(1, 5, 0, 0, "R4 write5");
    idle(30, "R4 n5");
    // R4/R5: writes on every cycle, hitting every period position
    for (int k = 0; k < 300; k++) cyc(1, (k / 3) % 5, 0, 0, "R4 R5 stream");
    idle(20, "R5 settle");
    // R5: divided -> pass-through mid-period, and back
    cyc(1, 2, 0, 0, "R5 to2");
    idle(6, "R5 n2");
    cyc(1, 0, 0, 0, "R5 to0");
    idle(8, "R5 pass");
    cyc(1, 4, 0, 0, "R5 to4");
    idle(20, "R5 n4");
    // R7: low-power flag has no effect on division
    cyc(0, 0, 1, 1, "R7 lp set");
    idle(20, "R7 n4 lp");
    cyc(0, 0, 1, 0, "R7 lp clr");
    idle(4, "R7");
    // R1: largest ratio, measure pulse spacing directly
    cyc(1, 255, 1, 1, "R1 write255");
    last = -1;
    for (int i = 0; i < 1200; i++) begin
      cyc(0, 0, 0, 0, "R1 n255");
      if (cclk_en && m_n == 255) begin
        if (last >= 0) begin
          gap = i - last;
          chk("R1 spacing 510", gap, 510);
        end
        last = i;
      end
    end
    // R8: reset mid-run clears everything
    do_reset();
    idle(5, "R8 after 2nd reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule